// File: doc/BRIEF.md
# Timestamping Event Capture Unit

This block sits on an arbitrated address-event bus and records each event it accepts into an output FIFO. A free-running 32-bit time counter provides the timestamp. It advances once per tick, and software selects a tick period of 1, 10, 50 or 100 microseconds. Every captured event becomes a self-describing record of tagged 18-bit words. The top two bits of each word name its type, so a reader that loses its place can find the start of the next record again.

Software controls the block through one control register and one status register, using plain write strobes and a combinational read. The control register holds a per-channel ignore mask, an option to store the address alone without a timestamp, the counter enable and clear bits, the tick select, and active-low enables for three interrupt flags. The flags record a rise to half-full, a lost event and a drain to empty. Each flag is cleared by writing a one to its bit position in the status register. The FIFO is read through a pop strobe, and its head word is always visible.

Top module: `evcap_top`

## Requirements
- R1: After reset the FIFO is empty, `fifo_rd_data` is 0, `ev_ready` is 1, `irq` is 0, the status read (address 0) is 0x010, and the control read (address 1) is 0xE60.
- R2: Each word is {type[1:0], payload[15:0]}, with type 00 = event address, 01 = upper timestamp half, 10 = lower timestamp half and 11 = reserved control. A timestamped record is written as address, then upper half, then lower half, on three consecutive cycles.
- R3: The timestamp in a record equals the counter value in the cycle when `ev_valid` was accepted.
- R4: With control bit 5 = 0, the counter increments once every CLK_PER_US x {1,10,50,100} clocks, selected by control bits 8:7 = 0..3. With bit 5 = 1, the counter holds its value.
- R5: While control bit 6 is 0, the counter and its prescaler are forced to zero.
- R6: Control bits 3:0 are per-channel masks. An event on a channel whose bit is 1 is accepted but writes nothing.
- R7: With control bit 4 = 1, only the address word is stored and `ev_ready` stays high.
- R8: If the free slots are fewer than the words an event needs (3, or 1 with bit 4 set), none of its words are written, and status flag bit 1 is set when control bit 10 is 0.
- R9: Status flag bit 0 is set in the cycle the fill level rises to DEPTH/2 or above, if control bit 9 is 0.
- R10: Status flag bit 2 is set in the cycle the fill level falls to 0, if control bit 11 is 0.
- R11: A write to address 0 clears each flag whose bit in the written value is 1. The written value is not stored, and a flag being set in the same cycle stays set. Status read bits 4, 5 and 6 show empty, at-least-half and full.
- R12: After a timestamped event is accepted, `ev_ready` is low for two cycles and other `ev_valid` pulses during that time are ignored. `irq` is the OR of the three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Event present on the bus |
| ev_chan | input | 2 | Channel that carried the event |
| ev_addr | input | 16 | Event address |
| ev_ready | output | 1 | Capture idle; a valid event is taken this cycle |
| fifo_rd | input | 1 | Pop the head word |
| fifo_rd_data | output | 18 | Head word, 0 when empty |
| fifo_empty | output | 1 | FIFO holds no word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = control |
| reg_wdata | input | 12 | Register write value |
| reg_rdata | output | 12 | Register read value for `reg_addr` |
| irq | output | 1 | Any flag set |

## Verification
The assertions assume that `reg_wr`, `fifo_rd` and `ev_valid` are clean single-cycle levels sampled at the rising edge, and that `ev_chan` and `ev_addr` only matter in a cycle where an event is taken. They also assume that control writes can land in any cycle, including in the middle of a record. The stimulus changes inputs only a short time after the falling edge. It holds each pulse for exactly one cycle, and it issues pops against an empty FIFO and events during busy cycles freely, because the block is required to tolerate both.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  localparam int PAYLOAD_W = 16;
  localparam int WORD_W    = PAYLOAD_W + 2;
  localparam int TIME_W    = 2 * PAYLOAD_W;
  localparam int N_CHAN    = 4;
  localparam int CHAN_W    = $clog2(N_CHAN);
  localparam int CTL_W     = 12;
  localparam int N_FLAG    = 3;

  // control register bit positions
  localparam int CTL_STAMP_OFF = 4;
  localparam int CTL_CNT_EN_N  = 5;
  localparam int CTL_CNT_CLR_N = 6;
  localparam int CTL_TSEL_LO   = 7;
  localparam int CTL_IE_LO     = 9;
  localparam logic [CTL_W-1:0] CTL_RESET = 12'hE60;

  // flag bit positions
  localparam int FLG_HF = 0;
  localparam int FLG_FF = 1;
  localparam int FLG_EF = 2;

  typedef enum logic [1:0] {
    TAG_ADDR = 2'b00,
    TAG_THI  = 2'b01,
    TAG_TLO  = 2'b10,
    TAG_CTL  = 2'b11
  } word_tag_e;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_HI   = 2'd1,
    CAP_LO   = 2'd2
  } cap_state_e;

  function automatic logic [31:0] tick_cycles(input logic [1:0] sel,
                                              input int unsigned clk_per_us);
    logic [31:0] us;
    case (sel)
      2'd0:    us = 32'd1;
      2'd1:    us = 32'd10;
      2'd2:    us = 32'd50;
      default: us = 32'd100;
    endcase
    return us * clk_per_us;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input word_tag_e tag,
                                                  input logic [PAYLOAD_W-1:0] payload);
    return {tag, payload};
  endfunction

  function automatic logic has_room(input logic [31:0] cnt, input logic [31:0] depth,
                                    input logic [31:0] need);
    return (cnt + need) <= depth;
  endfunction

endpackage

// File: rtl/evcap_timebase.sv
module evcap_timebase import evcap_pkg::*; #(
  parameter int CLK_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic [1:0]        tsel,
  output logic [TIME_W-1:0] time_cnt
);
  localparam int PW = $clog2(100 * CLK_PER_US + 1);

  logic [PW-1:0] pre;
  logic [31:0]   lim_m1;
  logic          tick;

  assign lim_m1 = tick_cycles(tsel, CLK_PER_US) - 32'd1;
  assign tick   = 32'(pre) >= lim_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      time_cnt <= '0;
    end else if (!clr_n) begin
      pre      <= '0;
      time_cnt <= '0;
    end else if (!en_n) begin
      if (tick) begin
        pre      <= '0;
        time_cnt <= time_cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo import evcap_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CW-1:0]     cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign head = (cnt != '0) ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/evcap_capture.sv
module evcap_capture import evcap_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [CHAN_W-1:0]    ev_chan,
  input  logic [PAYLOAD_W-1:0] ev_addr,
  input  logic [N_CHAN-1:0]    chan_mask,
  input  logic                 stamp_off,
  input  logic [TIME_W-1:0]    time_cnt,
  input  logic [CW-1:0]        fifo_cnt,
  output logic                 ev_ready,
  output logic                 wr_en,
  output logic [WORD_W-1:0]    wr_word,
  output logic                 ev_drop
);
  cap_state_e        state;
  logic [TIME_W-1:0] snap;
  logic              hit, room, push_addr;
  logic [31:0]       need;

  assign ev_ready  = (state == CAP_IDLE);
  assign hit       = ev_valid && ev_ready && !chan_mask[ev_chan];
  assign need      = stamp_off ? 32'd1 : 32'd3;
  assign room      = has_room(32'(fifo_cnt), 32'(DEPTH), need);
  assign push_addr = hit && room;
  assign ev_drop   = hit && !room;
  assign wr_en     = push_addr || (state != CAP_IDLE);

  always_comb begin
    case (state)
      CAP_HI:  wr_word = pack_word(TAG_THI, snap[TIME_W-1:PAYLOAD_W]);
      CAP_LO:  wr_word = pack_word(TAG_TLO, snap[PAYLOAD_W-1:0]);
      default: wr_word = pack_word(TAG_ADDR, ev_addr);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CAP_IDLE;
      snap  <= '0;
    end else begin
      case (state)
        CAP_IDLE: if (push_addr && !stamp_off) begin
          state <= CAP_HI;
          snap  <= time_cnt;
        end
        CAP_HI:  state <= CAP_LO;
        default: state <= CAP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evcap_irq.sv
module evcap_irq import evcap_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [CW-1:0]     cnt,
  input  logic              ev_drop,
  input  logic [N_FLAG-1:0] ie_n,
  input  logic              clr_en,
  input  logic [N_FLAG-1:0] clr_mask,
  output logic [N_FLAG-1:0] flags,
  output logic              hf_rise,
  output logic              ef_fall
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0]     cnt_next;
  logic [N_FLAG-1:0] set_v, clr_v;

  assign cnt_next = cnt + CW'(push) - CW'(pop);
  assign hf_rise  = (cnt < HALF) && (cnt_next >= HALF);
  assign ef_fall  = (cnt != '0) && (cnt_next == '0);

  always_comb begin
    set_v         = '0;
    set_v[FLG_HF] = hf_rise && !ie_n[FLG_HF];
    set_v[FLG_FF] = ev_drop && !ie_n[FLG_FF];
    set_v[FLG_EF] = ef_fall && !ie_n[FLG_EF];
    clr_v         = clr_en ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end
endmodule

// File: rtl/evcap_top.sv
module evcap_top import evcap_pkg::*; #(
  parameter int DEPTH      = 16,
  parameter int CLK_PER_US = 125
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [CHAN_W-1:0]    ev_chan,
  input  logic [PAYLOAD_W-1:0] ev_addr,
  output logic                 ev_ready,
  input  logic                 fifo_rd,
  output logic [WORD_W-1:0]    fifo_rd_data,
  output logic                 fifo_empty,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [CTL_W-1:0]     reg_wdata,
  output logic [CTL_W-1:0]     reg_rdata,
  output logic                 irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CTL_W-1:0]  ctrl;
  logic [TIME_W-1:0] time_cnt;
  logic [CW-1:0]     fifo_cnt;
  logic              wr_en, rd_pop, ev_drop, hf_rise, ef_fall;
  logic [WORD_W-1:0] wr_word;
  logic [N_FLAG-1:0] flags;
  logic              lvl_half, lvl_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl <= CTL_RESET;
    else if (reg_wr && reg_addr) ctrl <= reg_wdata;
  end

  assign fifo_empty = (fifo_cnt == '0);
  assign lvl_half   = fifo_cnt >= CW'(DEPTH / 2);
  assign lvl_full   = fifo_cnt == CW'(DEPTH);
  assign rd_pop     = fifo_rd && !fifo_empty;
  assign irq        = |flags;

  always_comb begin
    if (reg_addr) reg_rdata = ctrl;
    else reg_rdata = {{(CTL_W-7){1'b0}}, lvl_full, lvl_half, fifo_empty, 1'b0, flags};
  end

  evcap_timebase #(.CLK_PER_US(CLK_PER_US)) tb_i (
    .clk(clk), .rst_n(rst_n),
    .en_n(ctrl[CTL_CNT_EN_N]), .clr_n(ctrl[CTL_CNT_CLR_N]),
    .tsel(ctrl[CTL_TSEL_LO +: 2]), .time_cnt(time_cnt)
  );

  evcap_capture #(.DEPTH(DEPTH), .CW(CW)) cap_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_addr(ev_addr),
    .chan_mask(ctrl[N_CHAN-1:0]), .stamp_off(ctrl[CTL_STAMP_OFF]),
    .time_cnt(time_cnt), .fifo_cnt(fifo_cnt),
    .ev_ready(ev_ready), .wr_en(wr_en), .wr_word(wr_word), .ev_drop(ev_drop)
  );

  evcap_fifo #(.DEPTH(DEPTH), .CW(CW)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(wr_en), .push_word(wr_word), .pop(rd_pop),
    .head(fifo_rd_data), .cnt(fifo_cnt)
  );

  evcap_irq #(.DEPTH(DEPTH), .CW(CW)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .push(wr_en), .pop(rd_pop), .cnt(fifo_cnt), .ev_drop(ev_drop),
    .ie_n(ctrl[CTL_IE_LO +: N_FLAG]),
    .clr_en(reg_wr && !reg_addr), .clr_mask(reg_wdata[N_FLAG-1:0]),
    .flags(flags), .hf_rise(hf_rise), .ef_fall(ef_fall)
  );
endmodule

// File: rtl/evcap_chk.sv
module evcap_chk import evcap_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [CTL_W-1:0]  reg_wdata,
  input logic [CTL_W-1:0]  ctrl,
  input logic [N_FLAG-1:0] flags,
  input logic [TIME_W-1:0] time_cnt,
  input logic [CW-1:0]     fifo_cnt,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic              ev_drop,
  input logic              hf_rise,
  input logic              rd_pop
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R8
  drop_sets_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ctrl[CTL_IE_LO + FLG_FF]) |=> flags[FLG_FF]);

  // R11
  hf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[FLG_HF] && !hf_rise) |=> !flags[FLG_HF]);

  // R12
  busy_after_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && wr_en && !ctrl[CTL_STAMP_OFF]) |=> !ev_ready);

  // R2
  busy_word_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_ready) |-> (wr_word[WORD_W-1 -: 2] != TAG_ADDR));

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTL_CNT_CLR_N] |=> (time_cnt == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTL_CNT_EN_N] && ctrl[CTL_CNT_CLR_N]) |=> $stable(time_cnt));

  // R10
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_cnt == CW'(1) && !wr_en && !ctrl[CTL_IE_LO + FLG_EF]) |=> flags[FLG_EF]);
endmodule

bind evcap_top evcap_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl(ctrl),
  .flags(flags), .time_cnt(time_cnt), .fifo_cnt(fifo_cnt), .wr_en(wr_en),
  .wr_word(wr_word), .ev_drop(ev_drop), .hf_rise(hf_rise), .rd_pop(rd_pop)
);

// File: tb/evcap_top_tb_top.sv
module evcap_top_tb_top;
  localparam int D   = 8;
  localparam int CPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_chan = '0;
  logic [15:0] ev_addr = '0;
  logic        fifo_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [11:0] reg_wdata = '0;
  logic        rsel = 1'b0;
  wire         ev_ready, fifo_empty, irq;
  wire  [17:0] fifo_rd_data;
  wire  [11:0] reg_rdata;

  always #4 clk = ~clk;

  evcap_top #(.DEPTH(D), .CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_addr(ev_addr), .ev_ready(ev_ready), .fifo_rd(fifo_rd),
    .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [17:0] q[$];
  logic [11:0] m_ctrl;
  logic [2:0]  m_flags;
  logic [31:0] m_time, m_snap;
  int          m_pre, m_st;

  function automatic int tick_len(logic [1:0] s);
    int us[4] = '{1, 10, 50, 100};
    return us[s] * CPU;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ctrl = 12'hE60; m_flags = '0; m_time = '0;
      m_snap = '0; m_pre = 0; m_st = 0;
    end else begin
      int oc, nc, need;
      bit has_push, pop, drop;
      logic [17:0] w;
      logic [2:0] setv, clrv;
      oc = q.size(); has_push = 0; drop = 0; w = '0;
      pop = fifo_rd && oc > 0;
      if (m_st == 1) begin w = {2'b01, m_snap[31:16]}; has_push = 1; m_st = 2; end
      else if (m_st == 2) begin w = {2'b10, m_snap[15:0]}; has_push = 1; m_st = 0; end
      else if (ev_valid && !m_ctrl[ev_chan]) begin
        need = m_ctrl[4] ? 1 : 3;
        if (oc + need > D) drop = 1;
        else begin
          w = {2'b00, ev_addr}; has_push = 1;
          if (!m_ctrl[4]) begin m_snap = m_time; m_st = 1; end
        end
      end
      if (pop) void'(q.pop_front());
      if (has_push) q.push_back(w);
      nc = q.size();
      setv = '0;
      setv[0] = (oc < D/2) && (nc >= D/2) && !m_ctrl[9];
      setv[1] = drop && !m_ctrl[10];
      setv[2] = (oc > 0) && (nc == 0) && !m_ctrl[11];
      clrv = (reg_wr && !reg_addr) ? reg_wdata[2:0] : 3'b0;
      m_flags = (m_flags & ~clrv) | setv;
      if (!m_ctrl[6]) begin m_time = '0; m_pre = 0; end
      else if (!m_ctrl[5]) begin
        if (m_pre >= tick_len(m_ctrl[8:7]) - 1) begin m_pre = 0; m_time = m_time + 1; end
        else m_pre = m_pre + 1;
      end
      if (reg_wr && reg_addr) m_ctrl = reg_wdata;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [11:0] er;
      int n;
      n = q.size();
      er = reg_addr ? m_ctrl
                    : {5'b0, n == D, n >= D/2, n == 0, 1'b0, m_flags};
      chk("ev_ready", 32'(ev_ready), 32'(m_st == 0));
      chk("fifo_empty", 32'(fifo_empty), 32'(n == 0));
      chk("fifo_rd_data", 32'(fifo_rd_data), (n > 0) ? 32'(q[0]) : 32'd0);
      chk("irq", 32'(irq), 32'(m_flags != 0));
      chk("reg_rdata", 32'(reg_rdata), 32'(er));
    end
  end

  task automatic step(bit v = 0, logic [1:0] c = 0, logic [15:0] a = 0, bit rd = 0,
                      bit wr = 0, bit wa = 0, logic [11:0] wd = 0);
    @(negedge clk); #2;
    ev_valid = v; ev_chan = c; ev_addr = a; fifo_rd = rd;
    reg_wr = wr; reg_addr = wr ? wa : rsel; reg_wdata = wd;
  endtask
  task automatic idle(int n); repeat (n) step(); endtask
  task automatic wctrl(logic [11:0] v); step(.wr(1), .wa(1), .wd(v)); endtask
  task automatic wclr(logic [11:0] m); step(.wr(1), .wa(0), .wd(m)); endtask
  task automatic send(logic [1:0] c, logic [15:0] a); step(.v(1), .c(c), .a(a)); idle(2); endtask
  task automatic drain(); repeat (D + 2) step(.rd(1)); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b1;
    tag = "R1"; idle(3);                    // reset values
    rsel = 1'b1; idle(2); rsel = 1'b0;      // control default
    tag = "R2"; wctrl(12'hE40);             // counter on, 1 us tick
    send(0, 16'h26FE); send(1, 16'hF433);
    rsel = 1'b1; drain(); rsel = 1'b0;
    tag = "R3"; idle(7); send(2, 16'h3344); idle(13); send(3, 16'hAD22); drain();
    tag = "R4";
    for (int s = 0; s < 4; s++) begin
      wctrl(12'hE40 | 12'(s << 7)); idle(450); send(1, 16'(16'h100 + s)); drain();
    end
    wctrl(12'hE60); idle(50); send(0, 16'h0BAD); drain();
    tag = "R5"; wctrl(12'hE00); idle(5); send(0, 16'h0C1E); wctrl(12'hE40); drain();
    tag = "R6"; wctrl(12'hE45);
    for (int c = 0; c < 4; c++) send(2'(c), 16'(16'hA000 + c));
    drain();
    tag = "R7"; wctrl(12'hE50);
    step(.v(1), .c(0), .a(16'h7001)); step(.v(1), .c(1), .a(16'h7002));
    step(.v(1), .c(3), .a(16'h7003)); drain();
    tag = "R12"; wctrl(12'hE40);
    repeat (4) step(.v(1), .c(2), .a(16'h5A5A));
    drain();
    tag = "R8"; wctrl(12'hA40);
    send(0, 16'h0001); send(0, 16'h0002); send(0, 16'h0003);
    wctrl(12'hA50);
    send(1, 16'h0004); send(1, 16'h0005); send(1, 16'h0006);
    tag = "R11"; wclr(12'hFF5); idle(2); wclr(12'h002); idle(2);
    rsel = 1'b1; idle(2); rsel = 1'b0;
    tag = "R10"; wctrl(12'h040); drain(); idle(2);
    tag = "R9"; wclr(12'h007);
    send(0, 16'h1111); send(1, 16'h2222); idle(3);
    tag = "R11"; step(.v(1), .c(0), .a(16'h3333), .wr(1), .wa(0), .wd(12'h007)); idle(3);
    drain(); wclr(12'h007); idle(2);
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3)
        wctrl(12'($urandom) | 12'h040);
      else if (r < 6)
        wclr(12'($urandom));
      else
        step(.v(($urandom % 3) == 0), .c(2'($urandom)), .a(16'($urandom)),
             .rd(($urandom % 2) == 0));
      if ((i % 50) == 0) rsel = ~rsel;
    end
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule